// File: doc/BRIEF.md
# Synchronized Four-Channel DAC Register Bank

This block holds the digital side of a four-channel, 12-bit digital-to-analog output stage. A host writes through a simple register port. Each channel has a holding register and an output register. The output register is what the external converter model sees.

In synchronous mode, a data write only fills the holding register. A write of any value to the strobe offset then moves all four holding values to the outputs on the same clock edge, so the channels change together. With synchronous mode off, a data write reaches its channel's output on the next clock edge.

One byte-wide range register carries a 2-bit range code for every channel. Range changes apply at once and are never held back by the strobe. The host port is a plain register interface with no back-pressure: every write is taken in the cycle in which `wr_en` is high, and reads are combinational.

Top module: `dac_sync_bank`

## Requirements
- R1: After reset every output code and every holding register is 0x800, the range register is 0xAA and synchronous mode is on (`sync_mode` = 1).
- R2: A write to byte offset 2n (n = 0..3) loads channel n's holding register with bits 11:0 of the written word; bits 15:12 are discarded.
- R3: While synchronous mode is on, a data write leaves every output code unchanged.
- R4: A write of any value to offset 9 copies all four holding registers to the output codes on the same clock edge; the new codes are visible after that edge.
- R5: While synchronous mode is off, a data write to channel n sets output code n, visible after the edge that takes the write; the other channels keep their outputs.
- R6: Offset 8 is the range register. Channel n's range is bits 2n+1:2n, and it appears on `dac_range` right after the write edge, whatever the mode. A strobe does not change it. Reading offset 8 returns the register in bits 7:0 and zeros above.
- R7: Bit 0 of a write to offset 15 sets synchronous mode (1 = on). Reading offset 15 returns the mode in bit 0 and zeros above. Changing the mode does not move any output code.
- R8: Writes to offsets 1, 3, 5, 7 and 10 to 14 change no output, range or mode. Reads of any offset other than 8 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, taken on the rising edge |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 16 | Combinational read data |
| dac_code | output | 48 | Output codes, channel n at bits 12n+11:12n |
| dac_range | output | 8 | Range codes, channel n at bits 2n+1:2n |
| sync_mode | output | 1 | Synchronous output mode flag |

## Verification
The hardest case to reach from the ports is a holding register that differs from its output. This only arises in synchronous mode after several data writes and before a strobe. It matters most when synchronous mode is then switched off, because the pending values must stay hidden until a strobe or a fresh write. The bench mixes directed sequences that build this state on purpose with a long seeded random run. In that run, mode toggles, strobes and data writes are interleaved heavily, so the holding and output registers drift apart and come back together many times. A bench model tracks both register layers and is checked after every operation.

// File: rtl/dac_sync_pkg.sv
package dac_sync_pkg;
  localparam int OFS_RANGE  = 8;
  localparam int OFS_STROBE = 9;
  localparam int OFS_SYNC   = 15;
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] ch_load,
  output logic              range_we,
  output logic              strobe,
  output logic              sync_we
);
  import dac_sync_pkg::*;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ch_load[n] = wr_en && (wr_addr == ADDR_W'(2 * n));
  end

  assign range_we = wr_en && (wr_addr == ADDR_W'(OFS_RANGE));
  assign strobe   = wr_en && (wr_addr == ADDR_W'(OFS_STROBE));
  assign sync_we  = wr_en && (wr_addr == ADDR_W'(OFS_SYNC));
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
  parameter int          CODE_W = 12,
  parameter logic [11:0] MID    = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              direct,
  input  logic              strobe,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] out_code
);
  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= CODE_W'(MID);
      out_code <= CODE_W'(MID);
    end else begin
      if (load)
        hold_q <= din;
      if (strobe)
        out_code <= hold_q;
      else if (load && direct)
        out_code <= din;
    end
  end

  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !direct && !strobe) |=> $stable(out_code)); // R3
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && direct && !strobe) |=> (out_code == $past(din))); // R5
  AST_STROBE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (out_code == $past(hold_q))); // R4
endmodule

// File: rtl/dac_mode_regs.sv
module dac_mode_regs #(
  parameter int           RNG_W     = 8,
  parameter logic [RNG_W-1:0] RNG_RST = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             range_we,
  input  logic             sync_we,
  input  logic [RNG_W-1:0] din,
  output logic [RNG_W-1:0] range_q,
  output logic             sync_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_q <= RNG_RST;
      sync_q  <= 1'b1;
    end else begin
      if (range_we)
        range_q <= din;
      if (sync_we)
        sync_q <= din[0];
    end
  end

  AST_RANGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    range_we |=> (range_q == $past(din))); // R6
  AST_RANGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !range_we |=> $stable(range_q)); // R6
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_we |=> (sync_q == $past(din[0]))); // R7
endmodule

// File: rtl/dac_sync_bank.sv
module dac_sync_bank #(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 12,
  parameter int RANGE_W = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_CH*CODE_W-1:0]  dac_code,
  output logic [NUM_CH*RANGE_W-1:0] dac_range,
  output logic                      sync_mode
);
  import dac_sync_pkg::*;

  localparam int          RNG_W   = NUM_CH * RANGE_W;
  localparam logic [11:0] MID     = 12'(1 << (CODE_W - 1));
  localparam logic [RNG_W-1:0] RNG_RST = {NUM_CH{RANGE_W'(2)}};

  logic [NUM_CH-1:0] ch_load;
  logic              range_we, strobe, sync_we;
  logic [RNG_W-1:0]  range_q;
  logic              sync_q;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

  dac_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .ch_load(ch_load),
    .range_we(range_we), .strobe(strobe), .sync_we(sync_we)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
    dac_chan_slot #(.CODE_W(CODE_W), .MID(MID)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(ch_load[n]), .direct(!sync_q),
      .strobe(strobe), .din(wr_data[CODE_W-1:0]),
      .out_code(dac_code[n*CODE_W +: CODE_W])
    );
  end

  dac_mode_regs #(.RNG_W(RNG_W), .RNG_RST(RNG_RST)) u_mode (
    .clk(clk), .rst_n(rst_n), .range_we(range_we), .sync_we(sync_we),
    .din(wr_data[RNG_W-1:0]), .range_q(range_q), .sync_q(sync_q)
  );

  assign dac_range = range_q;
  assign sync_mode = sync_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_RANGE))
      rd_data = DATA_W'(range_q);
    else if (rd_addr == ADDR_W'(OFS_SYNC))
      rd_data = DATA_W'(sync_q);
  end

  logic wr_unmapped;
  assign wr_unmapped = wr_en && !(|ch_load) && !range_we && !strobe && !sync_we;

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(dac_code) && $stable(dac_range) && $stable(sync_mode))); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_load, range_we, strobe, sync_we})); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dac_code) && $stable(sync_mode))); // R3
endmodule

// File: tb/dac_sync_bank_tb.sv
module dac_sync_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic [47:0] dac_code;
  logic [7:0]  dac_range;
  logic        sync_mode;

  always #10 clk = ~clk;

  dac_sync_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dac_code(dac_code), .dac_range(dac_range), .sync_mode(sync_mode)
  );

  int checks = 0;
  int errors = 0;
  logic [11:0] hold_m [4];
  logic [11:0] out_m  [4];
  logic [7:0]  range_m;
  logic        sync_m;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    if (a == 4'd8) return {8'h00, range_m};
    if (a == 4'd15) return {15'h0, sync_m};
    return 16'h0000;
  endfunction

  task automatic check_state(input string tag);
    for (int ch = 0; ch < 4; ch++)
      chk(tag, 32'(dac_code[ch*12 +: 12]), 32'(out_m[ch]));
    chk(tag, 32'(dac_range), 32'(range_m));
    chk(tag, 32'(sync_mode), 32'(sync_m));
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp_read(a)));
  endtask

  function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
    if (a < 4'd8 && a[0] == 1'b0) begin
      hold_m[a[2:1]] = d[11:0];
      if (!sync_m) out_m[a[2:1]] = d[11:0];
    end else if (a == 4'd8) range_m = d[7:0];
    else if (a == 4'd9) begin
      for (int ch = 0; ch < 4; ch++) out_m[ch] = hold_m[ch];
    end else if (a == 4'd15) sync_m = d[0];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(a, d);
    check_state(tag);
  endtask

  function automatic string tag_of(input logic [3:0] a);
    if (a < 4'd8 && a[0] == 1'b0) return sync_m ? "R3" : "R5";
    if (a == 4'd8) return "R6";
    if (a == 4'd9) return "R4";
    if (a == 4'd15) return "R7";
    return "R8";
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] odd_list [9];
    void'($urandom(32'd4242));
    odd_list = '{4'd1, 4'd3, 4'd5, 4'd7, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14};
    for (int ch = 0; ch < 4; ch++) begin hold_m[ch] = 12'h800; out_m[ch] = 12'h800; end
    range_m = 8'hAA; sync_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");
    rd_chk(4'd8, "R1");
    rd_chk(4'd15, "R1");

    // R2/R3: upper bits dropped, output held in sync mode
    wr(4'd4, 16'hF123, "R3");
    wr(4'd0, 16'h0ABC, "R3");
    wr(4'd9, 16'h0000, "R4");
    chk("R2", 32'(dac_code[24 +: 12]), 32'h123);
    // R6: range immediate, strobe leaves it
    wr(4'd8, 16'hFF1B, "R6");
    chk("R6", 32'(dac_range[3:2]), 32'h2);
    wr(4'd9, 16'h1234, "R6");
    rd_chk(4'd8, "R6");
    // R7: pending hold stays hidden when leaving sync mode
    wr(4'd6, 16'h0777, "R3");
    wr(4'd15, 16'hFFFE, "R7");
    wr(4'd15, 16'h0000, "R7");
    rd_chk(4'd15, "R7");
    chk("R7", 32'(dac_code[36 +: 12]), 32'h800);
    // R5: direct write, other channels unchanged
    wr(4'd2, 16'h0FFF, "R5");
    wr(4'd9, 16'h0, "R4");
    // R8: unmapped writes and zero reads
    for (int i = 0; i < 9; i++) wr(odd_list[i], 16'hFFFF, "R8");
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R8");
    wr(4'd15, 16'h0001, "R7");

    for (int k = 0; k < 600; k++) begin
      logic [3:0] a;
      int r;
      string t;
      r = int'($urandom % 12);
      if (r < 5) a = 4'(2 * ($urandom % 4));
      else if (r == 5) a = 4'd8;
      else if (r < 8) a = 4'd9;
      else if (r == 8) a = 4'd15;
      else a = odd_list[$urandom % 9];
      t = tag_of(a);
      wr(a, 16'($urandom), t);
      rd_chk(4'($urandom % 16), "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule